// File: doc/BRIEF.md
# ADC Round-Robin Conversion Sequencer

This block schedules conversions for an analog-to-digital converter. It keeps sixteen conversion slots, each with its own input channel and sample-window length, and a pending bit per slot. A slot becomes pending when its selected trigger fires: an external strobe (slot 0 only), or one of two end-of-conversion interrupt pulses. A round-robin arbiter picks the next pending slot and sends its channel and window to the converter. When the result comes back it is written into that slot's result register, and the interrupts whose source field names that slot raise their flag and pulse.

Since interrupt pulses can trigger slots, slots can be chained. Typically slot 0 starts a burst and its interrupt fires slots 1 to 15 together. If slot 0 is also triggered by the interrupt that follows slot 15, the chain runs on its own until software removes that link. Each interrupt can be set to pulse on every event, or only while its flag is clear. In the second case, dependent slots stall until the flag is cleared.

The analog converter is a stub with fixed latency. Its result is the channel number in the top four bits, and the low bits hold a count of conversions completed since reset.

Top module: `adc_seq_top`

## Requirements
- R1: Each of the sixteen slots stores a 4-bit channel and an acquisition value, both written through the slot configuration port. When a slot is started, `conv_start` pulses for one cycle with `conv_slot`, `conv_chan` and `conv_win` carrying that slot's index and settings.
- R2: The sample window of a conversion lasts acquisition+1 cycles and is followed by LAT conversion cycles. The interrupt pulse for that slot appears exactly acquisition+LAT+3 cycles after the cycle in which `conv_start` is high.
- R3: Slot 0 is triggered by `ext_trig` only when its external-enable bit is set. It can also be triggered by interrupt 2, and both sources may be enabled together.
- R4: The trigger code of a slot selects the source: 0 means none, 1 means interrupt 1, 2 means interrupt 2, and 3 is treated as none. A slot with no source never converts.
- R5: Pending slots are served in round-robin order. After a slot is served, the search starts at the next higher index, so slots that are triggered together convert in ascending order.
- R6: Each interrupt has a 4-bit source field naming a slot. When that slot finishes, the interrupt's flag is set and its pulse is high for one cycle, in the same edge that writes the result.
- R7: An interrupt whose continuous bit is 0 does not pulse while its flag is already set. Slots triggered by it then stay idle until the flag is cleared.
- R8: Bit i of `flag_clr` (bit 0 = interrupt 1, bit 1 = interrupt 2) clears flag i when it is 1 and leaves flag i unchanged when it is 0. Flags are 0 after reset.
- R9: A trigger for a slot that is already pending merges into the existing request. A slot that receives several triggers while another conversion is in progress converts only once.
- R10: The result stored for a slot is {channel[3:0], conversion count[7:0]}, where the count is the number of conversions completed since reset, before this one. `res_data` shows the register selected by `res_addr` one cycle later.
- R11: When slot 15's interrupt 2 re-triggers slot 0 and every other slot follows interrupt 1 from slot 0, conversion runs continuously in order 0 to 15. After slot 0's link is removed, it stops once the current round ends with slot 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_trig | input | 1 | External trigger strobe for slot 0 |
| cfg_we | input | 1 | Slot configuration write strobe |
| cfg_slot | input | 4 | Slot being written |
| cfg_chan | input | 4 | Channel for the slot |
| cfg_acq | input | 9 | Acquisition value for the slot |
| cfg_trg | input | 2 | Trigger code for the slot |
| cfg_ext | input | 1 | External-enable bit, taken only when slot 0 is written |
| icfg_we | input | 1 | Interrupt configuration write strobe |
| icfg_idx | input | 1 | Interrupt being written (0 = interrupt 1, 1 = interrupt 2) |
| icfg_src | input | 4 | Source slot for the interrupt |
| icfg_cont | input | 1 | Continuous bit for the interrupt |
| flag_clr | input | 2 | Flag clear strobes, one bit per interrupt |
| res_addr | input | 4 | Result register read address |
| res_data | output | 12 | Registered read data of the result register |
| conv_start | output | 1 | One-cycle conversion request |
| conv_slot | output | 4 | Slot under conversion |
| conv_chan | output | 4 | Channel under conversion |
| conv_win | output | 9 | Acquisition value under conversion |
| irq_pulse | output | 2 | Interrupt pulses |
| irq_flag | output | 2 | Interrupt flags |

## Verification
A table of five slots with different channels and windows is fired as one burst from slot 0. This shows ascending service order, how each slot's settings are carried to the converter, the stored result values, and how the pulse delay depends on two different window lengths. The bench then repeats bursts with a non-continuous interrupt, with and without clearing its flag in between, to separate a stall from a missed trigger, and clears one flag bit at a time. Repeated external strobes during a busy conversion show merging, as opposed to queueing. A slot 0 that has both external and interrupt-2 triggers shows the two paths working together. A full sixteen-slot loop runs for three rounds and is then broken, which shows both wrap-around order and a clean stop at slot 15.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam logic [1:0] TRG_NONE = 2'd0;
  localparam logic [1:0] TRG_IRQ1 = 2'd1;
  localparam logic [1:0] TRG_IRQ2 = 2'd2;

  typedef enum logic {ST_IDLE, ST_BUSY} seq_state_e;
endpackage

// File: rtl/adc_seq_arb.sv
module adc_seq_arb #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pend,
  input  logic          take,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int off = 0; off < N; off++) begin
      int cand;
      cand = (int'(ptr) + off) % N;
      if (!gnt_valid && pend[cand]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (take && gnt_valid)
      ptr <= (gnt_idx == IW'(N-1)) ? '0 : gnt_idx + 1'b1;
  end

  // R5: a grant always points at a pending slot
  assert_grant_pending_R5: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> pend[gnt_idx]);
endmodule

// File: rtl/adc_seq_stub.sv
module adc_seq_stub #(
  parameter int CH_W  = 4,
  parameter int ACQ_W = 9,
  parameter int RES_W = 12,
  parameter int LAT   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CH_W-1:0]  chan,
  input  logic [ACQ_W-1:0] win,
  output logic             done,
  output logic [RES_W-1:0] data
);
  localparam int CNT_W = $clog2((1 << ACQ_W) + LAT + 1);
  localparam int SEQ_W = RES_W - CH_W;

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [CH_W-1:0]  chan_q;
  logic [SEQ_W-1:0] seq;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      chan_q <= '0;
      seq    <= '0;
      data   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        cnt    <= CNT_W'(win) + CNT_W'(LAT);
        chan_q <= chan;
      end else if (busy) begin
        if (cnt == '0) begin
          done <= 1'b1;
          data <= {chan_q, seq};
          seq  <= seq + 1'b1;
          busy <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R2: a new conversion never starts while the previous one runs
  assert_stub_idle_R2: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/adc_seq_irq.sv
module adc_seq_irq #(
  parameter int IW = 4,
  parameter logic [IW-1:0] RST_SRC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_src,
  input  logic          cfg_cont,
  input  logic          eoc,
  input  logic [IW-1:0] eoc_slot,
  input  logic          clr,
  output logic          pulse,
  output logic          flag
);
  logic [IW-1:0] src;
  logic          cont;
  logic          hit;

  assign hit = eoc && (eoc_slot == src);

  always_ff @(posedge clk) begin
    if (rst) begin
      src   <= RST_SRC;
      cont  <= 1'b0;
      pulse <= 1'b0;
      flag  <= 1'b0;
    end else begin
      if (cfg_we) begin
        src  <= cfg_src;
        cont <= cfg_cont;
      end
      pulse <= 1'b0;
      if (hit) begin
        flag  <= 1'b1;
        pulse <= !flag || cont;
      end else if (clr) begin
        flag <= 1'b0;
      end
    end
  end

  // R7: a set flag blocks the next pulse unless continuous
  assert_no_repulse_R7: assert property (@(posedge clk) disable iff (rst)
    (flag && !cont) |=> !pulse);
  // R6: every pulse comes with its flag set
  assert_pulse_flag_R6: assert property (@(posedge clk) disable iff (rst)
    pulse |-> flag);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int N     = 16,
  parameter int CH_W  = 4,
  parameter int ACQ_W = 9,
  parameter int RES_W = 12,
  parameter int LAT   = 4,
  parameter int NIRQ  = 2,
  parameter int IW    = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_trig,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_slot,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic [ACQ_W-1:0] cfg_acq,
  input  logic [1:0]       cfg_trg,
  input  logic             cfg_ext,
  input  logic             icfg_we,
  input  logic             icfg_idx,
  input  logic [IW-1:0]    icfg_src,
  input  logic             icfg_cont,
  input  logic [NIRQ-1:0]  flag_clr,
  input  logic [IW-1:0]    res_addr,
  output logic [RES_W-1:0] res_data,
  output logic             conv_start,
  output logic [IW-1:0]    conv_slot,
  output logic [CH_W-1:0]  conv_chan,
  output logic [ACQ_W-1:0] conv_win,
  output logic [NIRQ-1:0]  irq_pulse,
  output logic [NIRQ-1:0]  irq_flag
);
  import adc_seq_pkg::*;

  logic [CH_W-1:0]  chan_r [N];
  logic [ACQ_W-1:0] acq_r  [N];
  logic [1:0]       trg_r  [N];
  logic             ext_en;
  logic [N-1:0]     pend, hit, take_mask;
  logic             gnt_valid, take;
  logic [IW-1:0]    gnt_idx;
  logic             stub_done;
  logic [RES_W-1:0] stub_data;
  logic [RES_W-1:0] res_mem [N];
  seq_state_e       state;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < N; s++) begin
        chan_r[s] <= '0;
        acq_r[s]  <= '0;
        trg_r[s]  <= TRG_NONE;
      end
      ext_en <= 1'b0;
    end else if (cfg_we) begin
      chan_r[cfg_slot] <= cfg_chan;
      acq_r[cfg_slot]  <= cfg_acq;
      trg_r[cfg_slot]  <= cfg_trg;
      if (cfg_slot == '0) ext_en <= cfg_ext;
    end
  end

  always_comb begin
    for (int s = 0; s < N; s++) begin
      hit[s] = (trg_r[s] == TRG_IRQ1 && irq_pulse[0]) ||
               (trg_r[s] == TRG_IRQ2 && irq_pulse[1]);
    end
    hit[0] = hit[0] || (ext_en && ext_trig);
  end

  assign take      = (state == ST_IDLE) && gnt_valid;
  assign take_mask = take ? (N'(1) << gnt_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~take_mask) | hit;
  end

  adc_seq_arb #(.N(N), .IW(IW)) u_arb (
    .clk(clk), .rst(rst), .pend(pend), .take(take),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      conv_start <= 1'b0;
      conv_slot  <= '0;
      conv_chan  <= '0;
      conv_win   <= '0;
    end else begin
      conv_start <= 1'b0;
      if (state == ST_IDLE) begin
        if (gnt_valid) begin
          state      <= ST_BUSY;
          conv_start <= 1'b1;
          conv_slot  <= gnt_idx;
          conv_chan  <= chan_r[gnt_idx];
          conv_win   <= acq_r[gnt_idx];
        end
      end else if (stub_done) begin
        state <= ST_IDLE;
      end
    end
  end

  adc_seq_stub #(.CH_W(CH_W), .ACQ_W(ACQ_W), .RES_W(RES_W), .LAT(LAT)) u_stub (
    .clk(clk), .rst(rst), .start(conv_start), .chan(conv_chan),
    .win(conv_win), .done(stub_done), .data(stub_data)
  );

  always_ff @(posedge clk) begin
    if (stub_done) res_mem[conv_slot] <= stub_data;
    res_data <= res_mem[res_addr];
  end

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    adc_seq_irq #(.IW(IW), .RST_SRC((i == 0) ? IW'(0) : IW'(N-1))) u_irq (
      .clk(clk), .rst(rst),
      .cfg_we(icfg_we && (int'(icfg_idx) == i)),
      .cfg_src(icfg_src), .cfg_cont(icfg_cont),
      .eoc(stub_done), .eoc_slot(conv_slot), .clr(flag_clr[i]),
      .pulse(irq_pulse[i]), .flag(irq_flag[i])
    );
  end

  // R1: a start request lasts one cycle
  assert_start_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  // R2: results return only while a conversion is outstanding
  assert_done_busy_R2: assert property (@(posedge clk) disable iff (rst)
    stub_done |-> (state == ST_BUSY));
endmodule

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;

  logic clk = 0, rst = 1, ext_trig = 0, cfg_we = 0, cfg_ext = 0;
  logic [3:0] cfg_slot = 0, cfg_chan = 0, icfg_src = 0, res_addr = 0;
  logic [8:0] cfg_acq = 0;
  logic [1:0] cfg_trg = 0, flag_clr = 0;
  logic icfg_we = 0, icfg_idx = 0, icfg_cont = 0;
  logic [11:0] res_data;
  logic conv_start;
  logic [3:0] conv_slot, conv_chan;
  logic [8:0] conv_win;
  logic [1:0] irq_pulse, irq_flag;

  adc_seq_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nlog = 0;
  int log_slot [256];
  int log_chan [256];
  int log_win  [256];
  int log_cyc  [256];
  int ip_cnt [2] = '{0, 0};
  int ip_cyc [2] = '{0, 0};

  always @(negedge clk) begin
    if (conv_start && nlog < 256) begin
      log_slot[nlog] = conv_slot;
      log_chan[nlog] = conv_chan;
      log_win[nlog]  = conv_win;
      log_cyc[nlog]  = cyc;
      nlog = nlog + 1;
    end
    for (int i = 0; i < 2; i++)
      if (irq_pulse[i]) begin ip_cnt[i] = ip_cnt[i] + 1; ip_cyc[i] = cyc; end
  end

  int checks = 0, errors = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_slot(input int s, input int ch, input int acq, input logic [1:0] trg, input bit ext);
    @(negedge clk);
    cfg_we = 1; cfg_slot = 4'(s); cfg_chan = 4'(ch); cfg_acq = 9'(acq); cfg_trg = trg; cfg_ext = ext;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_irq(input int idx, input int src, input bit cont);
    @(negedge clk);
    icfg_we = 1; icfg_idx = idx[0]; icfg_src = 4'(src); icfg_cont = cont;
    @(negedge clk);
    icfg_we = 0;
  endtask

  task automatic fire;
    @(negedge clk); ext_trig = 1;
    @(negedge clk); ext_trig = 0;
  endtask

  task automatic clear(input logic [1:0] v);
    @(negedge clk); flag_clr = v;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic read_res(input int s, output int v);
    @(negedge clk); res_addr = 4'(s);
    @(negedge clk); v = res_data;
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // slot, channel, acquisition
  localparam logic [15:0] VEC [5] = '{
    {4'd0, 4'h3, 8'd0}, {4'd1, 4'h9, 8'd2}, {4'd2, 4'hC, 8'd5},
    {4'd3, 4'h5, 8'd1}, {4'd7, 4'hA, 8'd3}};

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int base, v, n0, cnt0;
    wait_cyc(5);
    rst = 0;
    wait_cyc(2);
    chk(irq_flag == 2'b00, "R8 reset flags", irq_flag, 0);
    fire();
    wait_cyc(30);
    chk(nlog == 0, "R3 R4 no source no conversion", nlog, 0);

    // table burst
    for (int i = 0; i < 5; i++)
      set_slot(VEC[i][15:12], VEC[i][11:8], VEC[i][7:0],
               (i == 0) ? 2'd0 : 2'd1, i == 0);
    set_irq(0, 0, 1);
    set_irq(1, 2, 1);
    base = nlog;
    fire();
    wait_cyc(200);
    chk(nlog == base + 5, "R5 burst length", nlog - base, 5);
    for (int i = 0; i < 5; i++) begin
      int s, ch;
      s = VEC[i][15:12]; ch = VEC[i][11:8];
      chk(log_slot[base+i] == s, "R5 order", log_slot[base+i], s);
      chk(log_chan[base+i] == ch && log_win[base+i] == VEC[i][7:0], "R1 request fields",
          log_chan[base+i], ch);
      read_res(s, v);
      chk(v == ((ch << 8) | ((base + i) & 255)), "R10 result", v, (ch << 8) | ((base + i) & 255));
    end
    chk(ip_cyc[0] - log_cyc[base] == 0 + LAT + 3, "R2 delay acq0", ip_cyc[0] - log_cyc[base], LAT + 3);
    chk(ip_cyc[1] - log_cyc[base+2] == 5 + LAT + 3, "R2 delay acq5", ip_cyc[1] - log_cyc[base+2], LAT + 8);
    chk(ip_cnt[0] == 1 && ip_cnt[1] == 1, "R6 one pulse per source", ip_cnt[1], 1);
    chk(irq_flag == 2'b11, "R6 flags set", irq_flag, 3);
    clear(2'b10);
    chk(irq_flag == 2'b01, "R8 clear bit1 only", irq_flag, 1);
    clear(2'b01);
    chk(irq_flag == 2'b00, "R8 clear bit0", irq_flag, 0);

    // non-continuous stall
    set_irq(0, 0, 0);
    base = nlog;
    fire(); wait_cyc(200);
    chk(nlog == base + 5, "R7 first burst", nlog - base, 5);
    cnt0 = ip_cnt[0];
    fire(); wait_cyc(150);
    chk(nlog == base + 6 && log_slot[base+5] == 0, "R7 stalled dependents", nlog - base, 6);
    chk(ip_cnt[0] == cnt0 && irq_flag[0], "R7 no pulse while flag set", ip_cnt[0], cnt0);
    clear(2'b01);
    fire(); wait_cyc(200);
    chk(nlog == base + 11 && log_slot[base+10] == 7, "R7 resumes after clear", nlog - base, 11);

    // merge while busy (irq1 flag is set, so no chain)
    base = nlog;
    fire(); wait_cyc(1);
    fire(); wait_cyc(1);
    fire(); wait_cyc(100);
    chk(nlog == base + 2, "R9 merged triggers", nlog - base, 2);

    // slot 0 with both sources
    set_irq(0, 9, 0);
    set_irq(1, 0, 0);
    set_slot(0, 3, 0, 2'd2, 1);
    clear(2'b11);
    base = nlog;
    fire(); wait_cyc(100);
    chk(nlog == base + 2 && log_slot[base] == 0 && log_slot[base+1] == 0,
        "R3 ext then irq2 retrigger", nlog - base, 2);
    chk(irq_flag[1] == 1'b1, "R6 irq2 flag", irq_flag[1], 1);

    // continuous loop
    for (int s = 0; s < 16; s++)
      set_slot(s, s, 0, (s == 0) ? 2'd2 : 2'd1, s == 0);
    set_irq(0, 0, 1);
    set_irq(1, 15, 1);
    clear(2'b11);
    base = nlog;
    fire();
    for (int k = 0; k < 2000 && nlog < base + 40; k++) wait_cyc(1);
    set_slot(0, 0, 0, 2'd0, 1);
    wait_cyc(300);
    n0 = nlog;
    wait_cyc(100);
    chk(nlog == n0, "R4 R11 stopped", nlog, n0);
    chk(nlog - base == 48, "R11 three rounds", nlog - base, 48);
    for (int j = 0; j < 48; j++)
      if (log_slot[base+j] != j % 16)
        chk(0, "R11 loop order", log_slot[base+j], j % 16);
    chk(log_slot[nlog-1] == 15, "R11 ends at 15", log_slot[nlog-1], 15);
    read_res(15, v);
    chk(v == ((15 << 8) | ((base + 47) & 255)), "R10 last result", v, (15 << 8) | ((base + 47) & 255));
    finish_run();
  end
endmodule